// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block turns a six-bit operand specifier into an operand location. The upper three bits pick one of eight addressing modes and the lower three pick one of eight 16-bit general registers. The block owns the register file. Register 7 is the program counter and register 6 the hardware stack pointer. When decode logic pulses `start`, the sequencer does the following:

- It reads the chosen register.
- When the mode calls for it, it fetches the extension word that follows the instruction, or reads a pointer word from memory.
- It ends with a single `done` pulse. At that pulse it reports one of two results: a register index, or the memory address of the operand.

Any pending auto-increment or auto-decrement of a register is written in the clock edge that closes the `done` cycle. The caller can read it from the next cycle on. Memory reads use a simple port: `memReq` and `memAddr` are held until `memReady` is sampled high, and the word arrives on `memRdData` in that same cycle. A plain write port and a plain read port let the caller load and inspect the registers.

Program-counter modes are the general modes applied to register 7:

- Post-increment gives an immediate operand.
- Deferred post-increment gives an absolute address.
- Indexed modes give a PC-relative address, measured from the program counter after it has moved past the extension word.

Words are little-endian and must sit at even addresses. An odd word address raises an alignment error instead of starting the access.

Top module: `ea_sequencer`

## Requirements
- R1: Mode 0 (specMode=0) reports `operandIsReg`=1 and `operandReg` equal to the selected register. It makes no memory access, changes no register and never raises `alignErr`.
- R2: Mode 1 reports `operandAddr` equal to the register's value and leaves the register unchanged.
- R3: Mode 2 reports the old register value and then adds a step to the register. Mode 4 subtracts the step first and reports the new value. The step is 1 when `byteOp`=1 and 2 when `byteOp`=0. It is always 2 for register 6 and register 7.
- R4: Mode 3 (post-increment) and mode 5 (pre-decrement) always step the register by 2. They read the word at the pointer address (the old value for mode 3, the decremented value for mode 5). The word read becomes `operandAddr`.
- R5: Modes 6 and 7 fetch the extension word at the address in register 7 and advance register 7 by 2. Mode 6 reports the selected register plus the extension word, modulo 2^16.
- R6: In modes 6 and 7 on register 7, the base is the program counter after it has moved past the extension word. Mode 7, on any register, reads the word at the sum and reports that word.
- R7: Mode 2 on register 7 reports the old PC as `operandAddr` (an immediate operand) and advances the PC by 2. Mode 3 on register 7 reports the word stored at the old PC (an absolute address) and advances the PC by 2.
- R8: Each `start` produces exactly one single-cycle `done` pulse. Register updates are not visible while `done` is high. They are visible in the cycle after.
- R9: Each of the following raises `alignErr` with `done` and commits no register update:
  - an odd pointer address or an odd extension-word address, in which case that memory read is never issued;
  - an odd final address of a word operand (`byteOp`=0).
- R10: `memAddr` is always even while `memReq` is high. `memReq` and `memAddr` stay unchanged until `memReady` is seen.
- R11: `rfWrEn` writes `rfWrData` into register `rfWrIdx`. `rfRdData` always shows register `rfRdIdx`. All registers are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin resolving one specifier (taken when idle) |
| specMode | input | 3 | Addressing mode |
| specReg | input | 3 | Register number |
| byteOp | input | 1 | Operand is a byte |
| done | output | 1 | One-cycle completion pulse |
| operandIsReg | output | 1 | Result is a register, not an address |
| operandReg | output | 3 | Register index of the result |
| operandAddr | output | 16 | Memory address of the result |
| alignErr | output | 1 | Odd word address found, request aborted |
| memReq | output | 1 | Memory read request |
| memAddr | output | 16 | Memory read address |
| memReady | input | 1 | Read accepted, data valid |
| memRdData | input | 16 | Read data |
| rfWrEn | input | 1 | Register write strobe |
| rfWrIdx | input | 3 | Register write index |
| rfWrData | input | 16 | Register write data |
| rfRdIdx | input | 3 | Register read index |
| rfRdData | output | 16 | Register read data |

## Verification
A wrong stride or base shows up in two places:
- immediately, in `operandAddr` during the `done` cycle;
- one cycle later, in the register value seen through the read port.

A wrong sequencing state shows as a memory read that was never expected, a missing read, or a `done` pulse that comes early, comes twice or never arrives. The bench counts issued reads per request and bounds the wait for `done`. An alignment fault that commits anyway leaves a changed register on the read port in the cycle after `done`.

// File: rtl/ea_seq_pkg.sv
package ea_seq_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_CALC,
    SEQ_EXT,
    SEQ_PTR,
    SEQ_FIN
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic eval;
    logic takeExt;
    logic takePtr;
    logic commit;
  } seqStrobe_t;

  localparam int MODE_W = 3;
endpackage

// File: rtl/ea_seq_ctrl.sv
module ea_seq_ctrl
  import ea_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] curMode,
  input  logic              evalErr,
  input  logic              sumOdd,
  input  logic              memReady,
  output seqStrobe_t        stb,
  output logic              memReq,
  output logic              done
);
  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    stb = '0;
    case (state)
      SEQ_IDLE: if (start) begin
        stb.capture = 1'b1;
        nextState = SEQ_CALC;
      end
      SEQ_CALC: begin
        stb.eval = 1'b1;
        case (curMode)
          3'd3, 3'd5: nextState = evalErr ? SEQ_FIN : SEQ_PTR;
          3'd6, 3'd7: nextState = evalErr ? SEQ_FIN : SEQ_EXT;
          default:    nextState = SEQ_FIN;
        endcase
      end
      SEQ_EXT: if (memReady) begin
        stb.takeExt = 1'b1;
        nextState = (curMode == 3'd7 && !sumOdd) ? SEQ_PTR : SEQ_FIN;
      end
      SEQ_PTR: if (memReady) begin
        stb.takePtr = 1'b1;
        nextState = SEQ_FIN;
      end
      SEQ_FIN: begin
        stb.commit = 1'b1;
        nextState = SEQ_IDLE;
      end
      default: nextState = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= SEQ_IDLE;
    else       state <= nextState;

  assign memReq = (state == SEQ_EXT) || (state == SEQ_PTR);
  assign done   = (state == SEQ_FIN);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> memReq);
endmodule

// File: rtl/ea_seq_dp.sv
module ea_seq_dp
  import ea_seq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 8,
  parameter int PC_IDX  = 7,
  parameter int SP_IDX  = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqStrobe_t                 stb,
  input  logic [MODE_W-1:0]          inMode,
  input  logic [$clog2(REG_CNT)-1:0] inReg,
  input  logic                       inByte,
  input  logic [DATA_W-1:0]          memRdData,
  input  logic                       rfWrEn,
  input  logic [$clog2(REG_CNT)-1:0] rfWrIdx,
  input  logic [DATA_W-1:0]          rfWrData,
  input  logic [$clog2(REG_CNT)-1:0] rfRdIdx,
  output logic [DATA_W-1:0]          rfRdData,
  output logic [MODE_W-1:0]          curMode,
  output logic                       evalErr,
  output logic                       sumOdd,
  output logic [DATA_W-1:0]          memAddr,
  output logic                       resIsReg,
  output logic [$clog2(REG_CNT)-1:0] resReg,
  output logic [DATA_W-1:0]          resAddr,
  output logic                       errFlag
);
  localparam int IDX_W = $clog2(REG_CNT);
  localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);
  localparam logic [IDX_W-1:0] SP_SEL = IDX_W'(SP_IDX);
  localparam logic [DATA_W-1:0] WORD_STEP = DATA_W'(2);
  localparam logic [DATA_W-1:0] BYTE_STEP = DATA_W'(1);

  logic [DATA_W-1:0] rf [REG_CNT];
  logic              specByte;
  logic [DATA_W-1:0] ptrAddr, pendVal;
  logic [IDX_W-1:0]  pendIdx;
  logic              pendValid;

  logic [DATA_W-1:0] base, pcNow, pcNext, stepAmt, decVal, extBase, extSum;
  logic              pinnedReg, deferMode;

  assign base      = rf[resReg];
  assign pcNow     = rf[PC_SEL];
  assign pcNext    = pcNow + WORD_STEP;
  assign pinnedReg = (resReg == PC_SEL) || (resReg == SP_SEL);
  assign deferMode = (curMode == 3'd3) || (curMode == 3'd5);
  assign stepAmt   = (specByte && !pinnedReg && !deferMode) ? BYTE_STEP : WORD_STEP;
  assign decVal    = base - stepAmt;
  assign extBase   = (resReg == PC_SEL) ? pcNext : base;
  assign extSum    = extBase + memRdData;
  assign sumOdd    = extSum[0];
  assign rfRdData  = rf[rfRdIdx];
  assign memAddr   = ptrAddr;

  always_comb begin
    case (curMode)
      3'd1, 3'd2: evalErr = base[0] && !specByte;
      3'd4:       evalErr = decVal[0] && !specByte;
      3'd3, 3'd5: evalErr = decVal[0] && curMode == 3'd5 || base[0] && curMode == 3'd3;
      3'd6, 3'd7: evalErr = pcNow[0];
      default:    evalErr = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++) rf[i] <= '0;
    end else if (stb.commit && pendValid && !errFlag) begin
      rf[pendIdx] <= pendVal;
    end else if (rfWrEn) begin
      rf[rfWrIdx] <= rfWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode <= '0; resReg <= '0; specByte <= 1'b0;
      ptrAddr <= '0; pendVal <= '0; pendIdx <= '0; pendValid <= 1'b0;
      resIsReg <= 1'b0; resAddr <= '0; errFlag <= 1'b0;
    end else begin
      if (stb.capture) begin
        curMode   <= inMode;
        resReg    <= inReg;
        specByte  <= inByte;
        pendValid <= 1'b0;
        errFlag   <= 1'b0;
        resIsReg  <= 1'b0;
      end
      if (stb.eval) begin
        errFlag <= evalErr;
        case (curMode)
          3'd0: resIsReg <= 1'b1;
          3'd1: resAddr <= base;
          3'd2: begin
            resAddr <= base;
            pendIdx <= resReg; pendVal <= base + stepAmt; pendValid <= 1'b1;
          end
          3'd3: begin
            ptrAddr <= base;
            pendIdx <= resReg; pendVal <= base + stepAmt; pendValid <= 1'b1;
          end
          3'd4: begin
            resAddr <= decVal;
            pendIdx <= resReg; pendVal <= decVal; pendValid <= 1'b1;
          end
          3'd5: begin
            ptrAddr <= decVal;
            pendIdx <= resReg; pendVal <= decVal; pendValid <= 1'b1;
          end
          default: ptrAddr <= pcNow;
        endcase
      end
      if (stb.takeExt) begin
        pendIdx <= PC_SEL; pendVal <= pcNext; pendValid <= 1'b1;
        if (curMode == 3'd6) begin
          resAddr <= extSum;
          errFlag <= extSum[0] && !specByte;
        end else begin
          ptrAddr <= extSum;
          errFlag <= extSum[0];
        end
      end
      if (stb.takePtr) begin
        resAddr <= memRdData;
        errFlag <= memRdData[0] && !specByte;
      end
    end
  end

  assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.commit && !rfWrEn) |=> $stable(rf[PC_SEL]));
  assert_no_update_on_error_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && errFlag && !rfWrEn) |=> $stable(rf[pendIdx]));
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
  import ea_seq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 8,
  localparam int REG_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] specMode,
  input  logic [REG_W-1:0]  specReg,
  input  logic              byteOp,
  output logic              done,
  output logic              operandIsReg,
  output logic [REG_W-1:0]  operandReg,
  output logic [DATA_W-1:0] operandAddr,
  output logic              alignErr,
  output logic              memReq,
  output logic [DATA_W-1:0] memAddr,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              rfWrEn,
  input  logic [REG_W-1:0]  rfWrIdx,
  input  logic [DATA_W-1:0] rfWrData,
  input  logic [REG_W-1:0]  rfRdIdx,
  output logic [DATA_W-1:0] rfRdData
);
  seqStrobe_t        stb;
  logic [MODE_W-1:0] curMode;
  logic              evalErr, sumOdd;

  ea_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .curMode(curMode),
    .evalErr(evalErr), .sumOdd(sumOdd), .memReady(memReady),
    .stb(stb), .memReq(memReq), .done(done)
  );

  ea_seq_dp #(.DATA_W(DATA_W), .REG_CNT(REG_CNT), .PC_IDX(REG_CNT - 1), .SP_IDX(REG_CNT - 2)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inMode(specMode), .inReg(specReg),
    .inByte(byteOp), .memRdData(memRdData), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx),
    .rfWrData(rfWrData), .rfRdIdx(rfRdIdx), .rfRdData(rfRdData),
    .curMode(curMode), .evalErr(evalErr), .sumOdd(sumOdd), .memAddr(memAddr),
    .resIsReg(operandIsReg), .resReg(operandReg), .resAddr(operandAddr),
    .errFlag(alignErr)
  );

  assert_even_fetch_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !memAddr[0]);
  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> $stable(memAddr));
  assert_reg_result_clean_R1: assert property (@(posedge clk) disable iff (!rstN)
    (done && operandIsReg) |-> !alignErr);
endmodule

// File: tb/ea_sequencer_test.sv
`timescale 1ns/1ps
module ea_sequencer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  specMode = '0, specReg = '0;
  logic        byteOp = 1'b0;
  logic        done, operandIsReg, alignErr, memReq;
  logic [2:0]  operandReg;
  logic [15:0] operandAddr, memAddr, rfRdData;
  logic        memReady = 1'b0;
  logic [15:0] memRdData = '0;
  logic        rfWrEn = 1'b0;
  logic [2:0]  rfWrIdx = '0, rfRdIdx = '0;
  logic [15:0] rfWrData = '0;

  logic [15:0] mem [256];
  int          waitCnt = 0;
  int          readCnt = 0;
  int          compared = 0, mismatched = 0;

  logic        gotIsReg, gotErr;
  logic [2:0]  gotReg;
  logic [15:0] gotAddr, regDuringDone;

  always #2.5 clk = ~clk;

  ea_sequencer uut (
    .clk(clk), .rstN(rstN), .start(start), .specMode(specMode), .specReg(specReg),
    .byteOp(byteOp), .done(done), .operandIsReg(operandIsReg), .operandReg(operandReg),
    .operandAddr(operandAddr), .alignErr(alignErr), .memReq(memReq), .memAddr(memAddr),
    .memReady(memReady), .memRdData(memRdData), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx),
    .rfWrData(rfWrData), .rfRdIdx(rfRdIdx), .rfRdData(rfRdData)
  );

  always @(negedge clk) begin
    if (memReady) begin
      memReady <= 1'b0;
      waitCnt  <= 0;
    end else if (memReq) begin
      if (waitCnt >= 2) begin
        memReady  <= 1'b1;
        memRdData <= mem[memAddr[8:1]];
        readCnt   <= readCnt + 1;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setReg(input logic [2:0] idx, input logic [15:0] val);
    @(negedge clk);
    rfWrEn = 1'b1; rfWrIdx = idx; rfWrData = val;
    @(negedge clk);
    rfWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] idx, output logic [15:0] val);
    rfRdIdx = idx;
    #0.1;
    val = rfRdData;
  endtask

  task automatic resolve(input logic [2:0] m, input logic [2:0] r, input logic b);
    int t;
    int doneSeen;
    @(negedge clk);
    start = 1'b1; specMode = m; specReg = r; byteOp = b; rfRdIdx = r;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 50) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL R8 actual=no_done expected=done");
    end
    gotIsReg = operandIsReg; gotReg = operandReg; gotAddr = operandAddr;
    gotErr = alignErr; regDuringDone = rfRdData;
    @(negedge clk);
    doneSeen = done;
    check("R8 done single", 16'(doneSeen), 16'd0);
  endtask

  task automatic testReset();
    logic [15:0] v;
    check("R8 done reset", {15'd0, done}, 16'd0);
    check("R10 memReq reset", {15'd0, memReq}, 16'd0);
    for (int i = 0; i < 8; i++) begin
      readReg(3'(i), v);
      check("R11 reg reset", v, 16'h0000);
    end
  endtask

  task automatic testMode0();
    int rc;
    logic [15:0] v;
    setReg(3, 16'h1234);
    rc = readCnt;
    resolve(0, 3, 0);
    check("R1 isReg", {15'd0, gotIsReg}, 16'd1);
    check("R1 reg idx", {13'd0, gotReg}, 16'd3);
    check("R1 no err", {15'd0, gotErr}, 16'd0);
    check("R1 no read", 16'(readCnt - rc), 16'd0);
    readReg(3, v);
    check("R1 reg kept", v, 16'h1234);
    check("R11 write/read", v, 16'h1234);
  endtask

  task automatic testMode1();
    logic [15:0] v;
    setReg(2, 16'h0100);
    resolve(1, 2, 0);
    check("R2 addr", gotAddr, 16'h0100);
    check("R2 isReg", {15'd0, gotIsReg}, 16'd0);
    readReg(2, v);
    check("R2 reg kept", v, 16'h0100);
  endtask

  task automatic testStrides();
    logic [15:0] v;
    setReg(1, 16'h0101);
    resolve(2, 1, 1);
    check("R3 postinc byte addr", gotAddr, 16'h0101);
    check("R8 not yet updated", regDuringDone, 16'h0101);
    readReg(1, v);
    check("R3 postinc byte step", v, 16'h0102);
    resolve(2, 1, 0);
    check("R3 postinc word addr", gotAddr, 16'h0102);
    readReg(1, v);
    check("R3 postinc word step", v, 16'h0104);
    setReg(6, 16'h0200);
    resolve(2, 6, 1);
    readReg(6, v);
    check("R3 stack byte step 2", v, 16'h0202);
    setReg(2, 16'h0103);
    resolve(4, 2, 1);
    check("R3 predec byte addr", gotAddr, 16'h0102);
    readReg(2, v);
    check("R3 predec byte reg", v, 16'h0102);
    resolve(4, 6, 1);
    check("R3 stack predec addr", gotAddr, 16'h0200);
    readReg(6, v);
    check("R3 stack predec reg", v, 16'h0200);
  endtask

  task automatic testDeferred();
    logic [15:0] v;
    int rc;
    setReg(4, 16'h0040);
    rc = readCnt;
    resolve(3, 4, 1);
    check("R4 postinc deferred addr", gotAddr, 16'h0120);
    check("R4 one read", 16'(readCnt - rc), 16'd1);
    readReg(4, v);
    check("R4 step 2 on byte", v, 16'h0042);
    setReg(5, 16'h0044);
    resolve(5, 5, 1);
    check("R4 predec deferred addr", gotAddr, 16'h0130);
    readReg(5, v);
    check("R4 predec reg", v, 16'h0042);
  endtask

  task automatic testIndexed();
    logic [15:0] v;
    setReg(3, 16'h0100);
    setReg(7, 16'h0010);
    resolve(6, 3, 0);
    check("R5 index addr", gotAddr, 16'h0120);
    readReg(7, v);
    check("R5 pc advanced", v, 16'h0012);
    readReg(3, v);
    check("R5 base kept", v, 16'h0100);
    setReg(7, 16'h0014);
    resolve(6, 7, 0);
    check("R6 relative addr", gotAddr, 16'h0046);
    readReg(7, v);
    check("R6 pc after relative", v, 16'h0016);
    resolve(7, 7, 0);
    check("R6 relative deferred", gotAddr, 16'h0150);
    readReg(7, v);
    check("R6 pc after deferred", v, 16'h0018);
  endtask

  task automatic testPcModes();
    logic [15:0] v;
    resolve(2, 7, 1);
    check("R7 immediate addr", gotAddr, 16'h0018);
    readReg(7, v);
    check("R7 immediate pc", v, 16'h001A);
    resolve(3, 7, 0);
    check("R7 absolute addr", gotAddr, 16'h0160);
    readReg(7, v);
    check("R7 absolute pc", v, 16'h001C);
  endtask

  task automatic testAlign();
    logic [15:0] v;
    int rc;
    setReg(1, 16'h0101);
    resolve(1, 1, 0);
    check("R9 odd word err", {15'd0, gotErr}, 16'd1);
    rc = readCnt;
    resolve(3, 1, 1);
    check("R9 odd pointer err", {15'd0, gotErr}, 16'd1);
    check("R9 no read issued", 16'(readCnt - rc), 16'd0);
    readReg(1, v);
    check("R9 reg unchanged", v, 16'h0101);
    resolve(2, 1, 0);
    check("R9 postinc odd err", {15'd0, gotErr}, 16'd1);
    readReg(1, v);
    check("R9 postinc no update", v, 16'h0101);
    setReg(3, 16'h0101);
    setReg(7, 16'h0030);
    resolve(6, 3, 1);
    check("R9 odd byte ok", {15'd0, gotErr}, 16'd0);
    check("R9 odd byte addr", gotAddr, 16'h0103);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[16'h0040 >> 1] = 16'h0120;
    mem[16'h0042 >> 1] = 16'h0130;
    mem[16'h0010 >> 1] = 16'h0020;
    mem[16'h0014 >> 1] = 16'h0030;
    mem[16'h0016 >> 1] = 16'h0008;
    mem[16'h0020 >> 1] = 16'h0150;
    mem[16'h001A >> 1] = 16'h0160;
    mem[16'h0030 >> 1] = 16'h0002;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMode0();
    testMode1();
    testStrides();
    testDeferred();
    testIndexed();
    testPcModes();
    testAlign();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    mismatched++;
    compared++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule